// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block gathers interrupt events for a small 8-bit processor core and decides when the core is interrupted. There are two groups of sources. The core group has three sources: an edge on an external pin, a port-change event and a timer overflow. The peripheral group has a parameterized number of event lines. Each source has a sticky flag and an enable bit. A peripheral request must also pass a group enable. Every request then passes a global enable before it reaches the core. The wake-from-sleep output uses the same terms but is taken before the global enable.

Software reads and writes the flags and enables through a small register bus. The core sends a one-cycle pulse when it takes an interrupt, which clears the global enable. It sends another pulse on return from interrupt, which sets the global enable again. While the interrupt is being taken, the block drives a constant vector address.

The external pin goes through a two-flop synchronizer. A configurable rising or falling edge on the synchronized pin sets the pin flag.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, all flags, all enables, the group enable and the global enable are 0. `irq_o` and `wake_o` are low. The pin edge select is 1 (rising).
- R2: An event sets its flag on the next clock edge. This happens whatever the state of the flag's enable, the group enable or the global enable.
- R3: `irq_o` is high for a core source only when that source's flag, its enable and the global enable are all 1.
- R4: `irq_o` is high for a peripheral source only when that source's flag, its enable, the group enable and the global enable are all 1.
- R5: A `svc_take_i` pulse clears the global enable on the next clock edge, and this takes priority over a register write. `vector_o` always reads 0x0004.
- R6: A `ret_i` pulse, when no `svc_take_i` pulse is present, sets the global enable. If a flag is still pending at that point, `irq_o` rises again.
- R7: A flag falls only when software writes 0 to it. If a write of 0 lands in the same cycle as an event for that flag, the flag stays set.
- R8: The pin flag is set on the third rising clock edge after the pin change is first sampled. It is not set by the opposite edge. With edge select 1 the active edge is rising; with edge select 0 it is falling.
- R9: `wake_o` is high whenever some flag is set with its enable, and for a peripheral source also with the group enable. This holds whatever the value of the global enable.
- R10: The register map is as follows. Address 0 holds: bit 7 global enable, bit 6 group enable, bits 5:3 enables for timer/pin/port, and bits 2:0 flags for timer/pin/port. Address 1 holds the peripheral flags. Address 2 holds the peripheral enables. Address 3, bit 0, is the edge select. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | External interrupt pin, asynchronous |
| port_chg_i | input | 1 | Port-change event pulse |
| tmr_ovf_i | input | 1 | Timer overflow event pulse |
| periph_evt_i | input | NUM_PERIPH | Peripheral event pulses (0 EEPROM, 1 ADC, 2 serial, 3 capture, 4 timer A, 5 timer B) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| svc_take_i | input | 1 | Core is taking an interrupt |
| ret_i | input | 1 | Return from interrupt |
| irq_o | output | 1 | Interrupt request to the core |
| vector_o | output | VEC_W | Interrupt vector address |
| wake_o | output | 1 | Wake from sleep |

## Verification
The bench builds the block with its default parameters: six peripheral sources and a 13-bit vector of 0x0004. With six sources, the top peripheral bit (timer B, bit 5) and a mismatched flag/enable pair can both be exercised. A table of register settings covers each gating level one at a time. With the default two-stage synchronizer, the pin-flag latency can be probed exactly, one edge before and on the expected edge, for both edge polarities.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned CORE_N = 3;

  // core source index; also bit order inside address 0
  localparam int unsigned CORE_PORT = 0;
  localparam int unsigned CORE_PIN  = 1;
  localparam int unsigned CORE_TMR  = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_PFLAG = 2'd1;
  localparam logic [ADDR_W-1:0] A_PEN   = 2'd2;
  localparam logic [ADDR_W-1:0] A_CFG   = 2'd3;

  localparam int unsigned BIT_GE  = 7;
  localparam int unsigned BIT_PGE = 6;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  localparam int unsigned LEN = SYNC_N + 1;

  logic [LEN-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[LEN-2:0], pin_i};
  end

  // newest synchronized sample vs. one older
  logic cur, prev;
  assign cur  = sh_q[SYNC_N-1];
  assign prev = sh_q[SYNC_N];
  assign edge_o = rise_sel_i ? (cur & ~prev) : (~cur & prev);

  // R8: one active edge cannot be detected twice in a row
  a_r8_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o && $stable(rise_sel_i) |=> !edge_o || !$stable(rise_sel_i));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         flag_we_i,
  input  logic [W-1:0] flag_wd_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wd_i,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] flag_q, en_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[i] <= 1'b0;
      else if (flag_we_i) flag_q[i] <= flag_wd_i[i] | evt_i[i]; // event wins over clear
      else if (evt_i[i])  flag_q[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wd_i;
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign pend_o = flag_q & en_q;

  // R2 / R7: every event leaves its flag set
  a_r2_evt_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_o & $past(evt_i)) == $past(evt_i)));

  // R7: without a write no flag may fall
  a_r7_clear_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> (($past(flag_o) & ~flag_o) == '0));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 6,
  parameter int unsigned VEC_W      = 13,
  parameter logic [VEC_W-1:0] VEC_ADDR = 13'h0004,
  parameter int unsigned SYNC_N     = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pin_i,
  input  logic                  port_chg_i,
  input  logic                  tmr_ovf_i,
  input  logic [NUM_PERIPH-1:0] periph_evt_i,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  input  logic                  svc_take_i,
  input  logic                  ret_i,
  output logic                  irq_o,
  output logic [VEC_W-1:0]      vector_o,
  output logic                  wake_o
);
  logic wr_ctrl, wr_pflag, wr_pen, wr_cfg;
  assign wr_ctrl  = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_pflag = reg_we_i && (reg_addr_i == A_PFLAG);
  assign wr_pen   = reg_we_i && (reg_addr_i == A_PEN);
  assign wr_cfg   = reg_we_i && (reg_addr_i == A_CFG);

  // global / group enable, edge select
  logic ge_q, pge_q, rise_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ge_q   <= 1'b0;
      pge_q  <= 1'b0;
      rise_q <= 1'b1;
    end else begin
      if (svc_take_i)   ge_q <= 1'b0;
      else if (ret_i)   ge_q <= 1'b1;
      else if (wr_ctrl) ge_q <= reg_wdata_i[BIT_GE];
      if (wr_ctrl) pge_q  <= reg_wdata_i[BIT_PGE];
      if (wr_cfg)  rise_q <= reg_wdata_i[0];
    end
  end

  logic pin_edge;
  irq_sync_edge #(.SYNC_N(SYNC_N)) u_pin (
    .clk_i, .rst_ni, .pin_i, .rise_sel_i(rise_q), .edge_o(pin_edge)
  );

  logic [CORE_N-1:0] core_evt, core_flag, core_en, core_pend;
  always_comb begin
    core_evt            = '0;
    core_evt[CORE_PORT] = port_chg_i;
    core_evt[CORE_PIN]  = pin_edge;
    core_evt[CORE_TMR]  = tmr_ovf_i;
  end

  irq_flag_bank #(.W(CORE_N)) u_core (
    .clk_i, .rst_ni,
    .evt_i(core_evt),
    .flag_we_i(wr_ctrl), .flag_wd_i(reg_wdata_i[CORE_N-1:0]),
    .en_we_i(wr_ctrl),   .en_wd_i(reg_wdata_i[2*CORE_N-1:CORE_N]),
    .flag_o(core_flag), .en_o(core_en), .pend_o(core_pend)
  );

  logic [NUM_PERIPH-1:0] per_flag, per_en, per_pend;
  irq_flag_bank #(.W(NUM_PERIPH)) u_per (
    .clk_i, .rst_ni,
    .evt_i(periph_evt_i),
    .flag_we_i(wr_pflag), .flag_wd_i(reg_wdata_i[NUM_PERIPH-1:0]),
    .en_we_i(wr_pen),     .en_wd_i(reg_wdata_i[NUM_PERIPH-1:0]),
    .flag_o(per_flag), .en_o(per_en), .pend_o(per_pend)
  );

  logic wake_req;
  assign wake_req = (|core_pend) | (pge_q & (|per_pend));
  assign wake_o   = wake_req;
  assign irq_o    = ge_q & wake_req;
  assign vector_o = VEC_ADDR;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[BIT_GE]             = ge_q;
        reg_rdata_o[BIT_PGE]            = pge_q;
        reg_rdata_o[2*CORE_N-1:CORE_N]  = core_en;
        reg_rdata_o[CORE_N-1:0]         = core_flag;
      end
      A_PFLAG: reg_rdata_o[NUM_PERIPH-1:0] = per_flag;
      A_PEN:   reg_rdata_o[NUM_PERIPH-1:0] = per_en;
      default: reg_rdata_o[0] = rise_q;
    endcase
  end

  // R3 / R4: no request to the core without global enable
  a_r3_irq_needs_ge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ge_q);
  // R5: taking an interrupt drops global enable
  a_r5_take_clears_ge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_take_i |=> !irq_o);
  // R6: return re-arms global enable
  a_r6_ret_sets_ge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && !svc_take_i |=> reg_rdata_o[BIT_GE] || reg_addr_i != A_CTRL);
  // R9: any request is also a wake
  a_r9_irq_implies_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> wake_o);
  // R4: peripheral-only pending without group enable cannot wake
  a_r4_group_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_pend == '0) && !pge_q |-> !wake_o);
endmodule

// File: tb/irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_tb_top;
  localparam int unsigned NP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pin = 1'b0, port_chg = 1'b0, tmr_ovf = 1'b0;
  logic [NP-1:0] pevt = '0;
  logic we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic svc = 1'b0, ret = 1'b0;
  logic irq, wake;
  logic [12:0] vec;

  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .port_chg_i(port_chg),
    .tmr_ovf_i(tmr_ovf), .periph_evt_i(pevt), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .svc_take_i(svc), .ret_i(ret), .irq_o(irq), .vector_o(vec), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  // {ctrl, pen, pflag, irq, wake}
  localparam int NV = 8;
  localparam logic [25:0] VEC_T [NV] = '{
    {8'h01, 8'h00, 8'h00, 1'b0, 1'b0},  // R3 flag only
    {8'h09, 8'h00, 8'h00, 1'b0, 1'b1},  // R9 flag+en, no ge
    {8'h89, 8'h00, 8'h00, 1'b1, 1'b1},  // R3 all set
    {8'h80, 8'h01, 8'h01, 1'b0, 1'b0},  // R4 no group enable
    {8'hC0, 8'h01, 8'h01, 1'b1, 1'b1},  // R4 full path
    {8'h40, 8'h01, 8'h01, 1'b0, 1'b1},  // R9 peripheral wake without ge
    {8'hC0, 8'h20, 8'h10, 1'b0, 1'b0},  // R4 flag/enable mismatch
    {8'hA4, 8'h00, 8'h00, 1'b1, 1'b1}   // R3 timer source
  };

  logic [7:0] d;

  initial begin : watchdog
    #200000;
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", {8'h0, d}, 16'h0000);
    rd(2'd1, d); chk("R1 pflag", {8'h0, d}, 16'h0000);
    rd(2'd2, d); chk("R1 pen", {8'h0, d}, 16'h0000);
    rd(2'd3, d); chk("R1 edge sel", {8'h0, d}, 16'h0001);
    chk("R1 irq/wake", {14'h0, irq, wake}, 16'h0000);
    chk("R5 vector", {3'h0, vec}, 16'h0004);

    // vector table, R10 bit layout in the entries
    for (int i = 0; i < NV; i++) begin
      wr(2'd2, VEC_T[i][17:10]);
      wr(2'd1, VEC_T[i][9:2]);
      wr(2'd0, VEC_T[i][25:18]);
      chk($sformatf("R3/R4/R9 vec%0d irq", i), {15'h0, irq}, {15'h0, VEC_T[i][1]});
      chk($sformatf("R3/R4/R9 vec%0d wake", i), {15'h0, wake}, {15'h0, VEC_T[i][0]});
      rd(2'd0, d); chk($sformatf("R10 vec%0d ctrl rb", i), {8'h0, d}, {8'h0, VEC_T[i][25:18]});
    end
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);

    // R2 flags set with everything masked
    @(negedge clk); pevt = 6'h08; tmr_ovf = 1'b1; port_chg = 1'b1;
    @(negedge clk); pevt = '0; tmr_ovf = 1'b0; port_chg = 1'b0;
    rd(2'd1, d); chk("R2 periph flag", {8'h0, d}, 16'h0008);
    rd(2'd0, d); chk("R2 core flags", {8'h0, d}, 16'h0005);
    chk("R2 no irq", {15'h0, irq}, 16'h0000);

    // R7 clear concurrent with event keeps flag
    @(negedge clk); we = 1'b1; addr = 2'd1; wdata = 8'h00; pevt = 6'h08;
    @(negedge clk); we = 1'b0; pevt = '0;
    rd(2'd1, d); chk("R7 clear vs event", {8'h0, d}, 16'h0008);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R7 write clears", {8'h0, d}, 16'h0000);

    // R5 / R6 take and return
    wr(2'd0, 8'h89);
    chk("R5 irq before take", {15'h0, irq}, 16'h0001);
    @(negedge clk); svc = 1'b1;
    @(negedge clk); svc = 1'b0;
    chk("R5 irq after take", {15'h0, irq}, 16'h0000);
    rd(2'd0, d); chk("R5 ge cleared", {15'h0, d[7]}, 16'h0000);
    chk("R5 wake kept", {15'h0, wake}, 16'h0001);
    @(negedge clk); svc = 1'b1; we = 1'b1; addr = 2'd0; wdata = 8'h89;
    @(negedge clk); svc = 1'b0; we = 1'b0;
    rd(2'd0, d); chk("R5 take beats write", {15'h0, d[7]}, 16'h0000);
    @(negedge clk); ret = 1'b1;
    @(negedge clk); ret = 1'b0;
    chk("R6 retrigger", {15'h0, irq}, 16'h0001);
    wr(2'd0, 8'h00);

    // R8 rising edge latency
    @(negedge clk); pin = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(2'd0, d); chk("R8 rise not yet", {15'h0, d[1]}, 16'h0000);
    @(negedge clk);
    rd(2'd0, d); chk("R8 rise set", {15'h0, d[1]}, 16'h0001);
    wr(2'd0, 8'h00);
    @(negedge clk); pin = 1'b0;
    repeat (4) @(negedge clk);
    rd(2'd0, d); chk("R8 falling ignored", {15'h0, d[1]}, 16'h0000);

    // R8 falling mode
    wr(2'd3, 8'h00);
    @(negedge clk); pin = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd0, d); chk("R8 rising ignored", {15'h0, d[1]}, 16'h0000);
    @(negedge clk); pin = 1'b0;
    @(negedge clk); @(negedge clk);
    rd(2'd0, d); chk("R8 fall not yet", {15'h0, d[1]}, 16'h0000);
    @(negedge clk);
    rd(2'd0, d); chk("R8 fall set", {15'h0, d[1]}, 16'h0001);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule